// File: doc/BRIEF.md
# Single-Wire Dimming Mode Selector

This block watches one control pin after power-up and decides how the device is to be dimmed. When the pin is first driven high and stays high for a short setup time, the device counts as started. A fixed selection window then opens. If the host drives a specific pattern inside that window, the block selects serial digital mode: the pin stays high for a minimum time, counted from its first rising edge, and then stays low for a minimum time. Otherwise the block selects duty-cycle mode, where the pin carries a modulated dimming signal.

The converter enable turns on a fixed delay after the window closes, whichever mode was chosen. While the device runs, the same pin acts as a shutdown control. A low that lasts the full shutdown time turns everything off. Shorter lows, which are normal modulation in duty-cycle mode, have no effect. After a shutdown, only a new high on the pin starts the sequence again, and the mode is chosen afresh.

All thresholds are parameters counted in ticks of an external microsecond timebase. The raw pin passes through a two-flop synchronizer inside the block. The `serial_ok` output tells a neighbouring serial receiver that it may decode frames.

Top module: `swire_mode_sel`

## Requirements
- R1: After reset with the pin low, `off` is 1, and `conv_on`, `mode_serial` and `serial_ok` are 0.
- R2: A high on the pin shorter than `T_SETUP` ticks does not start the device: `off` stays 1 and no mode is chosen.
- R3: High for at least `T_HI_MIN` ticks from the first rising edge, then low for at least `T_LO_MIN` ticks, all inside the window, selects serial mode: `mode_serial` = 1 once the window of `T_WIN` ticks has closed.
- R4: If the initial high lasts less than `T_HI_MIN` ticks before the pin goes low, duty-cycle mode is selected (`mode_serial` = 0).
- R5: If the low after a valid high ends before `T_LO_MIN` ticks, duty-cycle mode is selected.
- R6: If the required low has not completed when the window closes, duty-cycle mode is selected.
- R7: `conv_on` rises `T_DLY` ticks after the window closes, in both modes, and `mode_serial` does not change while `conv_on` is held.
- R8: `serial_ok` is 1 exactly when the device has started, its window has closed and serial mode was chosen. It is never 1 while `mode_serial` is 0.
- R9: A low held for `T_OFF` ticks in any started state sets `off` = 1 and clears `conv_on`, `mode_serial` and `serial_ok`.
- R10: Lows shorter than `T_OFF` ticks leave `conv_on` at 1 and do not change the mode.
- R11: After a shutdown, only a new high restarts the sequence, and the mode is chosen again from scratch on each start.
- R12: `conv_on` is never 1 while `off` is 1. `off` falls only while the synchronized pin is high and rises only while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle timebase pulse; all timing counts these |
| pin_raw | input | 1 | Asynchronous control pin |
| mode_serial | output | 1 | 1 = serial digital mode, 0 = duty-cycle mode |
| conv_on | output | 1 | Converter enable |
| off | output | 1 | Device is in shutdown or not yet started |
| serial_ok | output | 1 | Serial receiver may run |

## Verification
The bound checker checks several relations on every cycle:
- the converter enable and the shutdown flag are never both active;
- `serial_ok` never appears without serial mode, and is absent during shutdown;
- the mode is frozen while the converter runs;
- shutdown is entered only on a low pin and left only on a high pin.

Only the directed scenarios can show the timing windows. These are the setup-time rejection, each way the entry pattern can fail (high too short, low too short, low finishing after the window), the delayed enable, the tolerance of modulation lows and the restart into a different mode. Each of these depends on long runs of pin history that the checker does not rebuild.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SETUP = 3'd1,
    ST_SEL   = 3'd2,
    ST_DLY   = 3'd3,
    ST_RUN   = 3'd4
  } top_st_e;

  typedef enum logic [1:0] {
    PT_HIGH = 2'd0,
    PT_LOW  = 2'd1,
    PT_FAIL = 2'd2,
    PT_DONE = 2'd3
  } pat_st_e;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/swire_lowrun.sv
module swire_lowrun #(
  parameter int T_OFF = 8900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic long_low
);
  localparam int W = $clog2(T_OFF + 1);
  logic [W-1:0] cnt;

  // counts consecutive low ticks, saturating at the shutdown threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt <= '0;
    else if (pin)                            cnt <= '0;
    else if (tick && cnt != W'(T_OFF))       cnt <= cnt + 1'b1;
  end

  assign long_low = (cnt == W'(T_OFF));
endmodule

// File: rtl/swire_pattern.sv
module swire_pattern
  import swire_pkg::*;
#(
  parameter int T_HI_MIN = 100,
  parameter int T_LO_MIN = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic act,
  input  logic tick,
  input  logic pin,
  output logic found
);
  localparam int MX = (T_HI_MIN > T_LO_MIN) ? T_HI_MIN : T_LO_MIN;
  localparam int W  = $clog2(MX + 1);

  pat_st_e      ph;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PT_HIGH;
      cnt <= '0;
    end else if (clr) begin
      ph  <= PT_HIGH;
      cnt <= '0;
    end else if (act) begin
      unique case (ph)
        PT_HIGH: begin
          if (!pin) begin
            ph  <= (cnt >= W'(T_HI_MIN)) ? PT_LOW : PT_FAIL;
            cnt <= '0;
          end else if (tick && cnt != W'(T_HI_MIN)) begin
            cnt <= cnt + 1'b1;
          end
        end
        PT_LOW: begin
          if (pin) begin
            ph <= PT_FAIL;
          end else if (tick) begin
            if (cnt == W'(T_LO_MIN - 1)) ph <= PT_DONE;
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign found = (ph == PT_DONE);
endmodule

// File: rtl/swire_mode_sel.sv
module swire_mode_sel
  import swire_pkg::*;
#(
  parameter int T_SETUP  = 2,
  parameter int T_WIN    = 1000,
  parameter int T_HI_MIN = 100,
  parameter int T_LO_MIN = 260,
  parameter int T_DLY    = 2000,
  parameter int T_OFF    = 8900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic pin_raw,
  output logic mode_serial,
  output logic conv_on,
  output logic off,
  output logic serial_ok
);
  localparam int M1 = (T_SETUP > T_WIN) ? T_SETUP : T_WIN;
  localparam int M2 = (M1 > T_DLY) ? M1 : T_DLY;
  localparam int CW = $clog2(M2 + 1);

  logic pin_s, long_low, found;
  top_st_e st;
  logic [CW-1:0] cnt;

  swire_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_raw), .d_sync(pin_s)
  );

  swire_lowrun #(.T_OFF(T_OFF)) u_lowrun (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .pin(pin_s), .long_low(long_low)
  );

  swire_pattern #(.T_HI_MIN(T_HI_MIN), .T_LO_MIN(T_LO_MIN)) u_pat (
    .clk(clk), .rst_n(rst_n),
    .clr(st == ST_OFF),
    .act(st == ST_SETUP || st == ST_SEL),
    .tick(us_tick), .pin(pin_s), .found(found)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_OFF;
      cnt         <= '0;
      mode_serial <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          mode_serial <= 1'b0;
          cnt         <= '0;
          if (pin_s) st <= ST_SETUP;
        end
        ST_SETUP: begin
          if (!pin_s) begin
            st <= ST_OFF;
          end else if (us_tick) begin
            if (cnt == CW'(T_SETUP - 1)) begin
              st  <= ST_SEL;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_SEL: begin
          if (long_low) begin
            st <= ST_OFF;
          end else if (us_tick) begin
            if (cnt == CW'(T_WIN - 1)) begin
              st          <= ST_DLY;
              cnt         <= '0;
              mode_serial <= found;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DLY: begin
          if (long_low) begin
            st <= ST_OFF;
          end else if (us_tick) begin
            if (cnt == CW'(T_DLY - 1)) begin
              st  <= ST_RUN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (long_low) st <= ST_OFF;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign off       = (st == ST_OFF) || (st == ST_SETUP);
  assign conv_on   = (st == ST_RUN);
  assign serial_ok = mode_serial && ((st == ST_DLY) || (st == ST_RUN));
endmodule

// File: rtl/swire_mode_sel_chk.sv
module swire_mode_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_s,
  input logic mode_serial,
  input logic conv_on,
  input logic off,
  input logic serial_ok
);
  assert_en_not_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_on |-> !off);

  assert_ok_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serial_ok |-> mode_serial);

  assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (!serial_ok && !conv_on));

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_on && $past(conv_on)) |-> $stable(mode_serial));

  assert_wake_on_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off) |-> $past(pin_s));

  assert_sleep_on_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off) |-> !$past(pin_s));
endmodule

bind swire_mode_sel swire_mode_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode_serial(mode_serial),
  .conv_on(conv_on), .off(off), .serial_ok(serial_ok)
);

// File: tb/swire_mode_sel_tb.sv
module swire_mode_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic pin_raw = 1'b0;
  logic mode_serial, conv_on, off, serial_ok;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  swire_mode_sel #(
    .T_SETUP(4), .T_WIN(60), .T_HI_MIN(10), .T_LO_MIN(20), .T_DLY(15), .T_OFF(80)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pin_raw(pin_raw),
    .mode_serial(mode_serial), .conv_on(conv_on), .off(off), .serial_ok(serial_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    @(negedge clk);
    pin_raw = lvl;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic shut_down();
    hold(1'b0, 100);
  endtask

  task automatic t_reset();
    chk("R1", "off", off, 1'b1);
    chk("R1", "conv_on", conv_on, 1'b0);
    chk("R1", "mode_serial", mode_serial, 1'b0);
    chk("R1", "serial_ok", serial_ok, 1'b0);
  endtask

  task automatic t_glitch();
    hold(1'b1, 2);
    hold(1'b0, 40);
    chk("R2", "off after short high", off, 1'b1);
    chk("R2", "mode after short high", mode_serial, 1'b0);
  endtask

  task automatic t_serial_then_off();
    hold(1'b1, 20);
    hold(1'b0, 30);
    hold(1'b1, 25);                    // 75 cycles after rise
    chk("R3", "mode_serial", mode_serial, 1'b1);
    chk("R8", "serial_ok", serial_ok, 1'b1);
    chk("R7", "conv_on before delay", conv_on, 1'b0);
    hold(1'b1, 15);                    // 90 cycles after rise
    chk("R7", "conv_on after delay", conv_on, 1'b1);
    hold(1'b0, 70);
    chk("R10", "conv_on during short low", conv_on, 1'b1);
    chk("R10", "mode during short low", mode_serial, 1'b1);
    hold(1'b0, 20);
    chk("R9", "off", off, 1'b1);
    chk("R9", "conv_on", conv_on, 1'b0);
    chk("R9", "mode_serial", mode_serial, 1'b0);
    chk("R9", "serial_ok", serial_ok, 1'b0);
  endtask

  task automatic t_short_high();
    hold(1'b1, 5);
    hold(1'b0, 30);
    hold(1'b1, 40);
    chk("R4", "mode_serial", mode_serial, 1'b0);
    chk("R11", "restarted", off, 1'b0);
    chk("R8", "serial_ok in duty mode", serial_ok, 1'b0);
    hold(1'b1, 15);
    chk("R7", "conv_on duty mode", conv_on, 1'b1);
    for (int i = 0; i < 3; i++) begin
      hold(1'b0, 40);
      hold(1'b1, 10);
      chk("R10", "conv_on through modulation", conv_on, 1'b1);
    end
    shut_down();
    chk("R9", "off from duty mode", off, 1'b1);
  endtask

  task automatic t_short_low();
    hold(1'b1, 20);
    hold(1'b0, 10);
    hold(1'b1, 45);
    chk("R5", "mode_serial", mode_serial, 1'b0);
    shut_down();
  endtask

  task automatic t_late();
    hold(1'b1, 50);
    hold(1'b0, 25);
    chk("R6", "mode_serial", mode_serial, 1'b0);
    hold(1'b1, 15);
    chk("R6", "conv_on", conv_on, 1'b1);
    chk("R6", "mode held", mode_serial, 1'b0);
    shut_down();
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_glitch();
        t_serial_then_off();
        t_short_high();
        t_short_low();
        t_late();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule